// File: doc/BRIEF.md
# Per-Block Error Tally and Retirement Tracker

This block keeps a running tally of ECC error events for each block of a memory array and decides when a block should be taken out of service. Each event names a block index and says whether the error was corrected or could not be corrected. The event can come from the outcome reported after a read, from a real-time error line, or from both. Every block has its own saturating counter. The host programs a retirement threshold, can read back any block's tally and retirement flag, and can wipe the whole log in one command.

A block is retired once its tally goes strictly above the threshold. An uncorrectable error retires its block straight away, whatever the tally is. A retirement flag is sticky: only the clear-all command removes it. A single aggregate output tells the system that at least one block is retired.

The event input is a valid/ready stream. `evt_ready` is held high at all times, so an event is accepted in every cycle in which `evt_valid` is high. The source therefore never stalls. An accepted event that arrives in the same cycle as a clear-all is discarded. The threshold, the clear and the read port are plain control pins.

Top module: `errlog_retire`

## Requirements
- R1: After reset, every tally is 0, every retirement flag is 0, `any_retired` is 0, `rd_valid` is 0, and the threshold equals the THR_INIT parameter.
- R2: An accepted event (`evt_valid` high) adds one to the tally of block `evt_blk` and leaves every other block's tally unchanged. The new value is visible one clock after acceptance.
- R3: A tally that already holds 2^CNT_W-1 stays at that value when more events arrive.
- R4: A corrected event (`evt_uncorr`=0) sets the block's retirement flag only when the updated tally is strictly greater than the threshold. A tally equal to the threshold does not retire the block.
- R5: An uncorrectable event (`evt_uncorr`=1) sets the block's retirement flag in the same update, whatever the tally. It also adds one to the tally, following R3.
- R6: Once set, a retirement flag stays set until clear-all.
- R7: A `clr_all` pulse zeroes every tally and every flag one clock later. An event accepted in the same cycle is discarded.
- R8: `thr_wr` loads `thr_wdata` into the threshold. The new threshold applies to events accepted in later cycles. It is not applied to tallies already stored, and `clr_all` does not change it.
- R9: A read request (`rd_en` high with `rd_blk`) gives `rd_valid`=1 one clock later. At that point `rd_cnt` and `rd_retired` hold the block's tally and flag as they stood before that clock's update. `rd_valid` is 0 in the cycle after a clock with `rd_en` low.
- R10: `any_retired` is 1 exactly when at least one block's retirement flag is set.
- R11: `evt_ready` is always 1. While `evt_valid` is low, `evt_blk` and `evt_uncorr` have no effect on any tally or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Error event present |
| evt_ready | output | 1 | Always 1; events are never stalled |
| evt_blk | input | IDX_W | Block index of the event |
| evt_uncorr | input | 1 | 1 = uncorrectable, 0 = corrected |
| thr_wr | input | 1 | Load a new threshold |
| thr_wdata | input | CNT_W | Threshold value |
| clr_all | input | 1 | Zero all tallies and flags |
| rd_en | input | 1 | Read request |
| rd_blk | input | IDX_W | Block index to read |
| rd_valid | output | 1 | Read data valid (one cycle after `rd_en`) |
| rd_cnt | output | CNT_W | Tally of the block read |
| rd_retired | output | 1 | Retirement flag of the block read |
| any_retired | output | 1 | OR of all retirement flags |

## Verification
The bench builds the tracker with NUM_BLK=8, CNT_W=4 and THR_INIT=5. With a 4-bit tally, saturation at 15 is reached after a handful of events, so the directed tests and the random mix both hit it many times. Eight blocks mean that random events often land on the same block and cross the threshold. Thresholds of 0 and 15 can both be set, which exercises retirement on the first event and a threshold that a tally can never exceed.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
  typedef enum logic {
    EV_CORR   = 1'b0,
    EV_UNCORR = 1'b1
  } evt_kind_e;
endpackage

// File: rtl/errlog_cell.sv
module errlog_cell #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hit,
  input  errlog_pkg::evt_kind_e kind,
  input  logic [CNT_W-1:0] thr,
  output logic [CNT_W-1:0] cnt,
  output logic             retired
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             ret_q;
  logic             ret_set;

  // Saturating increment
  always_comb begin
    cnt_nxt = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);
    ret_set = (kind == errlog_pkg::EV_UNCORR) || (cnt_nxt > thr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ret_q <= 1'b0;
    end else if (clr) begin
      cnt_q <= '0;
      ret_q <= 1'b0;
    end else if (hit) begin
      cnt_q <= cnt_nxt;
      if (ret_set) ret_q <= 1'b1;
    end
  end

  assign cnt     = cnt_q;
  assign retired = ret_q;

  a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (retired && !clr) |=> retired);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && !retired));

  a_r5_uncorr: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr && kind == errlog_pkg::EV_UNCORR) |=> retired);

  a_r4_equal_no_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr && kind == errlog_pkg::EV_CORR && !retired &&
     ({1'b0, cnt} + (CNT_W+1)'(1) <= {1'b0, thr})) |=> !retired);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !clr) |=> ($stable(cnt) && $stable(retired)));
endmodule

// File: rtl/errlog_rdport.sv
module errlog_rdport #(
  parameter int NUM_BLK = 16,
  parameter int CNT_W   = 8,
  localparam int IDX_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_blk,
  input  logic [CNT_W-1:0] cnt_all [NUM_BLK],
  input  logic [NUM_BLK-1:0] ret_all,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_cnt,
  output logic             rd_retired
);
  logic [CNT_W-1:0] sel_cnt;
  logic             sel_ret;

  always_comb begin
    sel_cnt = '0;
    sel_ret = 1'b0;
    for (int i = 0; i < NUM_BLK; i++) begin
      if (rd_blk == IDX_W'(i)) begin
        sel_cnt = cnt_all[i];
        sel_ret = ret_all[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_cnt     <= '0;
      rd_retired <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_cnt     <= sel_cnt;
        rd_retired <= sel_ret;
      end
    end
  end

  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

// File: rtl/errlog_retire.sv
module errlog_retire #(
  parameter int NUM_BLK  = 16,
  parameter int CNT_W    = 8,
  parameter int THR_INIT = 8,
  localparam int IDX_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  output logic             evt_ready,
  input  logic [IDX_W-1:0] evt_blk,
  input  logic             evt_uncorr,
  input  logic             thr_wr,
  input  logic [CNT_W-1:0] thr_wdata,
  input  logic             clr_all,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_blk,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_cnt,
  output logic             rd_retired,
  output logic             any_retired
);
  import errlog_pkg::*;

  logic [CNT_W-1:0]   thr_q;
  logic [CNT_W-1:0]   cnt_all [NUM_BLK];
  logic [NUM_BLK-1:0] ret_all;
  evt_kind_e          kind;

  assign evt_ready = 1'b1;
  assign kind      = evt_uncorr ? EV_UNCORR : EV_CORR;

  always_ff @(posedge clk) begin
    if (!rst_n)      thr_q <= CNT_W'(THR_INIT);
    else if (thr_wr) thr_q <= thr_wdata;
  end

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    logic hit;
    assign hit = evt_valid && evt_ready && (evt_blk == IDX_W'(g));
    errlog_cell #(.CNT_W(CNT_W)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_all),
      .hit     (hit),
      .kind    (kind),
      .thr     (thr_q),
      .cnt     (cnt_all[g]),
      .retired (ret_all[g])
    );
  end

  errlog_rdport #(.NUM_BLK(NUM_BLK), .CNT_W(CNT_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_blk     (rd_blk),
    .cnt_all    (cnt_all),
    .ret_all    (ret_all),
    .rd_valid   (rd_valid),
    .rd_cnt     (rd_cnt),
    .rd_retired (rd_retired)
  );

  assign any_retired = |ret_all;

  a_r7_clear_any: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> !any_retired);

  a_r8_thr_load: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> (thr_q == $past(thr_wdata)));

  a_r8_thr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_wr |=> $stable(thr_q));

  a_r10_any_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (any_retired && !clr_all) |=> any_retired);
endmodule

// File: tb/tb_errlog_retire.sv
`timescale 1ns/1ps
module tb_errlog_retire;
  localparam int NB   = 8;
  localparam int CW   = 4;
  localparam int TI   = 5;
  localparam int IW   = 3;
  localparam int CMAX = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_valid = 0, evt_uncorr = 0, thr_wr = 0, clr_all = 0, rd_en = 0;
  logic [IW-1:0] evt_blk = '0, rd_blk = '0;
  logic [CW-1:0] thr_wdata = '0;
  logic evt_ready, rd_valid, rd_retired, any_retired;
  logic [CW-1:0] rd_cnt;

  always #2 clk = ~clk;

  errlog_retire #(.NUM_BLK(NB), .CNT_W(CW), .THR_INIT(TI)) dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_blk(evt_blk), .evt_uncorr(evt_uncorr), .thr_wr(thr_wr),
    .thr_wdata(thr_wdata), .clr_all(clr_all), .rd_en(rd_en), .rd_blk(rd_blk),
    .rd_valid(rd_valid), .rd_cnt(rd_cnt), .rd_retired(rd_retired),
    .any_retired(any_retired));

  int m_cnt [NB];
  bit m_ret [NB];
  int m_thr;
  bit e_rv, e_rr;
  int e_rc;
  int n_tests = 0, n_fail = 0;

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit m_any();
    for (int i = 0; i < NB; i++) if (m_ret[i]) return 1'b1;
    return 1'b0;
  endfunction

  // One clock: model update at the edge, compare at the following negedge
  task automatic step();
    int n;
    @(posedge clk);
    e_rv = rd_en;
    if (rd_en) begin e_rc = m_cnt[rd_blk]; e_rr = m_ret[rd_blk]; end
    if (clr_all) begin
      for (int i = 0; i < NB; i++) begin m_cnt[i] = 0; m_ret[i] = 0; end
    end else if (evt_valid) begin
      n = (m_cnt[evt_blk] == CMAX) ? CMAX : m_cnt[evt_blk] + 1;
      if (evt_uncorr || n > m_thr) m_ret[evt_blk] = 1'b1;
      m_cnt[evt_blk] = n;
    end
    if (thr_wr) m_thr = thr_wdata;
    @(negedge clk);
    chk("R11 evt_ready", evt_ready, 1);
    chk("R10 any_retired", any_retired, m_any());
    chk("R9 rd_valid", rd_valid, e_rv);
    if (e_rv) begin
      chk("R9/R2 rd_cnt", rd_cnt, e_rc);
      chk("R9/R4 rd_retired", rd_retired, e_rr);
    end
  endtask

  task automatic idle();
    evt_valid = 0; evt_uncorr = 0; thr_wr = 0; clr_all = 0; rd_en = 0;
  endtask

  task automatic ev(int b, bit u);
    idle(); evt_valid = 1; evt_blk = IW'(b); evt_uncorr = u; step(); idle();
  endtask

  task automatic rd(int b);
    idle(); rd_en = 1; rd_blk = IW'(b); step(); idle(); step();
  endtask

  task automatic set_thr(int t);
    idle(); thr_wr = 1; thr_wdata = CW'(t); step(); idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) begin m_cnt[i] = 0; m_ret[i] = 0; end
    m_thr = TI;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 any_retired", any_retired, 0);
    chk("R1 rd_valid", rd_valid, 0);
    rd(4); chk("R1 cnt", rd_cnt, 0); chk("R1 ret", rd_retired, 0);
    // R1 default threshold: TI events do not retire, one more does
    for (int k = 0; k < TI; k++) ev(6, 0);
    rd(6); chk("R1 thr default eq", rd_retired, 0); chk("R2 count", rd_cnt, TI);
    ev(6, 0); rd(6); chk("R1 thr default gt", rd_retired, 1);
    idle(); clr_all = 1; step(); idle();
    // R4 threshold equality vs exceed
    set_thr(3);
    for (int k = 0; k < 3; k++) ev(5, 0);
    rd(5); chk("R4 equal", rd_retired, 0); chk("R2 cnt3", rd_cnt, 3);
    rd(4); chk("R2 other block", rd_cnt, 0);
    ev(5, 0); rd(5); chk("R4 exceed", rd_retired, 1);
    // R5 uncorrectable
    ev(2, 1); rd(2); chk("R5 ret", rd_retired, 1); chk("R5 cnt", rd_cnt, 1);
    // R3 saturation
    for (int k = 0; k < 20; k++) ev(7, 0);
    rd(7); chk("R3 sat", rd_cnt, CMAX);
    // R11 invalid ignored
    idle(); evt_blk = 3'd0; evt_uncorr = 1; step(); idle();
    rd(0); chk("R11 ignored cnt", rd_cnt, 0); chk("R11 ignored ret", rd_retired, 0);
    // R6 sticky across threshold raise
    set_thr(15); ev(5, 0); rd(5); chk("R6 sticky", rd_retired, 1);
    // R7 clear beats event
    idle(); clr_all = 1; evt_valid = 1; evt_blk = 3'd1; evt_uncorr = 1; step(); idle();
    chk("R7 any", any_retired, 0);
    rd(1); chk("R7 cnt", rd_cnt, 0); chk("R7 ret", rd_retired, 0);
    // R8 threshold survives clear, not retroactive
    ev(3, 0); ev(3, 0); set_thr(0);
    rd(3); chk("R8 not retro", rd_retired, 0);
    ev(3, 0); rd(3); chk("R8 applied", rd_retired, 1);
    // Random mix compared each clock
    for (int k = 0; k < 3000; k++) begin
      evt_valid  = ($urandom_range(0, 99) < 60);
      evt_blk    = IW'($urandom_range(0, NB-1));
      evt_uncorr = ($urandom_range(0, 99) < 4);
      thr_wr     = ($urandom_range(0, 99) < 3);
      thr_wdata  = CW'($urandom_range(0, CMAX));
      clr_all    = ($urandom_range(0, 99) < 2);
      rd_en      = ($urandom_range(0, 99) < 50);
      rd_blk     = IW'($urandom_range(0, NB-1));
      step();
    end
    idle(); step();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule